// File: doc/BRIEF.md
# Doorbell Command Mailbox

This block is a memory-mapped mailbox through which a host hands one command at a time to a device and collects the outcome. The host fills a payload buffer, writes a command word holding an opcode, a command set and an input length, and then sets a doorbell bit in the control register. A small state machine checks the command against a built-in table of supported opcodes and forms a return code and an output length. It writes both back into the command and status registers, and only then drops the doorbell to signal completion.

The host side is a simple single-cycle request bus. Each request carries an address, a size code for 1, 2, 4 or 8 bytes, and right-justified write data. Read data comes back one cycle later. The register window sits below byte offset 0x20. The payload buffer occupies the addresses from 0x20 up to 0x20 plus the advertised payload size.

Top module: `mbox_regblk`

## Requirements
- R1: After reset, a read of offset 0x0 returns the capability word 0x0000_000B. Bits 4:0 hold the payload-size exponent (11, so 2048 bytes), bit 5 (interrupt support) reads 0 and bit 6 (background support) reads 0. The control, command, status and background-status words read zero.
- R2: A write that sets bit 32 of the 64-bit word at 0x0 (bit 0 of the 32-bit control register at 0x4) starts one command. The doorbell reads 1 until the fourth rising edge after the edge that accepted that write, and reads 0 after it.
- R3: Before the doorbell clears, the command word at 0x8 is rewritten. Bits 7:0 (opcode) and bits 15:8 (command set) become zero, bits 35:16 take the output length, and bits 63:36 keep the value the host wrote.
- R4: The capability word, the status word at 0x10 and the background-status word at 0x18 are read-only. Host writes to them leave their read values unchanged.
- R5: The status word carries the return code in bits 47:32, and every other bit reads zero. The codes are 0x0 success, 0x2 invalid input, 0x3 unsupported, 0x4 internal error, 0x6 busy and 0x16 invalid payload length.
- R6: Command set 0x00, opcode 0x01 (echo) returns success with an output length equal to its input length, and it leaves the payload buffer unchanged.
- R7: An echo whose input length exceeds the payload size (2048) returns 0x16 with output length 0. No reported output length ever exceeds the payload size.
- R8: Command set 0x00, opcode 0x02 (no-op) expects an input length of 0. With length 0 it returns success and output length 0. With any other length it returns 0x16 and output length 0.
- R9: Any opcode or command set missing from the table returns 0x3 with output length 0.
- R10: Payload accesses are little-endian at sizes 1, 2, 4 and 8 bytes (size code 0, 1, 2, 3). An access that is not naturally aligned has no effect, and a misaligned read returns 0.
- R11: While the doorbell is set, host writes to the command word and to the payload buffer have no effect.
- R12: A read request accepted on one rising edge presents its data, with the response-valid flag, after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Right-justified write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Right-justified read data |

## Verification
Read data is registered on the edge that accepts the request, so the bench samples it on the following falling edge. A command finishes on the fourth rising edge after the doorbell write. The bench polls the doorbell with back-to-back reads and expects four ones and then a zero; because a read captures the value from before its edge, the zero appears on the fifth read. After each table-driven command, the bench waits six cycles, which is past completion, before it reads the command and status words. The writes that test the frozen window are placed on the first and second edges after the doorbell write, while the doorbell is certainly set.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int LEN_W = 20;

  typedef enum logic [15:0] {
    RC_OK        = 16'h0000,
    RC_BAD_INPUT = 16'h0002,
    RC_UNSUP     = 16'h0003,
    RC_INTERNAL  = 16'h0004,
    RC_BUSY      = 16'h0006,
    RC_BAD_LEN   = 16'h0016
  } mbox_rc_e;

  typedef struct packed {
    mbox_rc_e         rc;
    logic [LEN_W-1:0] out_len;
  } mbox_result_t;

  // natural alignment of an access of 2**size bytes at byte offset ofs
  function automatic logic is_aligned(input logic [1:0] size, input logic [2:0] ofs);
    logic ok;
    case (size)
      2'd0:    ok = 1'b1;
      2'd1:    ok = (ofs[0] == 1'b0);
      2'd2:    ok = (ofs[1:0] == 2'b00);
      default: ok = (ofs == 3'b000);
    endcase
    return ok;
  endfunction

  function automatic logic [7:0] size_mask(input logic [1:0] size);
    logic [7:0] m;
    case (size)
      2'd0:    m = 8'h01;
      2'd1:    m = 8'h03;
      2'd2:    m = 8'h0F;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction

  function automatic logic [7:0] lane_mask(input logic [1:0] size, input logic [2:0] ofs);
    return size_mask(size) << ofs;
  endfunction

  function automatic logic [63:0] merge_bytes(input logic [63:0] old_w,
                                              input logic [63:0] new_w,
                                              input logic [7:0]  be);
    logic [63:0] r;
    r = old_w;
    for (int i = 0; i < 8; i++) begin
      if (be[i]) r[8*i +: 8] = new_w[8*i +: 8];
    end
    return r;
  endfunction

  function automatic logic [63:0] read_extract(input logic [63:0] word,
                                               input logic [1:0]  size,
                                               input logic [2:0]  ofs);
    logic [63:0] s;
    logic [7:0]  m;
    logic [63:0] bm;
    s = word >> {ofs, 3'b000};
    m = size_mask(size);
    for (int i = 0; i < 8; i++) bm[8*i +: 8] = {8{m[i]}};
    return s & bm;
  endfunction

  // supported-command table lookup and input-length check
  function automatic mbox_result_t mbox_check(input logic [7:0]       cset,
                                              input logic [7:0]       op,
                                              input logic [LEN_W-1:0] len,
                                              input logic [LEN_W-1:0] max_len);
    mbox_result_t r;
    r.rc      = RC_UNSUP;
    r.out_len = '0;
    if (cset == 8'h00 && op == 8'h01) begin
      if (len <= max_len) begin
        r.rc      = RC_OK;
        r.out_len = len;
      end else begin
        r.rc = RC_BAD_LEN;
      end
    end else if (cset == 8'h00 && op == 8'h02) begin
      r.rc = (len == '0) ? RC_OK : RC_BAD_LEN;
    end
    return r;
  endfunction

endpackage

// File: rtl/mbox_bus_lanes.sv
module mbox_bus_lanes
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PLD_BASE = 32,
  parameter int PLD_EXP  = 11,
  localparam int PLD_BYTES = 1 << PLD_EXP,
  localparam int PIDX_W    = PLD_EXP - 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [63:0]       wdata,
  output logic [7:0]        be,
  output logic [63:0]       wdata_al,
  output logic              acc_ok,
  output logic              hit_reg,
  output logic              hit_pld,
  output logic [1:0]        reg_word,
  output logic [PIDX_W-1:0] pld_idx
);

  logic [2:0]        ofs;
  logic [ADDR_W-1:0] pld_off;

  assign ofs      = addr[2:0];
  assign acc_ok   = is_aligned(size, ofs);
  assign be       = lane_mask(size, ofs);
  assign wdata_al = wdata << {ofs, 3'b000};

  assign hit_reg  = addr < ADDR_W'(PLD_BASE);
  assign pld_off  = addr - ADDR_W'(PLD_BASE);
  assign hit_pld  = !hit_reg && ({1'b0, pld_off} < (ADDR_W + 1)'(PLD_BYTES));
  assign reg_word = addr[4:3];
  assign pld_idx  = pld_off[PLD_EXP-1:3];

endmodule

// File: rtl/mbox_payload_ram.sv
module mbox_payload_ram #(
  parameter int WORDS = 256,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_be,
  input  logic [63:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_data
);

  for (genvar b = 0; b < 8; b++) begin : g_lane
    logic [7:0] lane_mem [WORDS];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) lane_mem[wr_idx] <= wr_data[8*b +: 8];
    end

    assign rd_data[8*b +: 8] = lane_mem[rd_idx];
  end

endmodule

// File: rtl/mbox_cmd_fsm.sv
module mbox_cmd_fsm
  import mbox_pkg::*;
#(
  parameter int PLD_EXP = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db,
  input  logic [63:0]      cmd_word,
  output logic             wb_pulse,
  output logic [15:0]      wb_rc,
  output logic [LEN_W-1:0] wb_len,
  output logic             rel_pulse
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1 << PLD_EXP);

  typedef enum logic [1:0] {S_IDLE, S_DECODE, S_WB, S_REL} fsm_e;

  fsm_e         state_q;
  mbox_result_t res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= S_IDLE;
      res_q.rc      <= RC_OK;
      res_q.out_len <= '0;
    end else begin
      case (state_q)
        S_IDLE:   if (db) state_q <= S_DECODE;
        S_DECODE: begin
          res_q   <= mbox_check(cmd_word[15:8], cmd_word[7:0], cmd_word[35:16], MAX_LEN);
          state_q <= S_WB;
        end
        S_WB:     state_q <= S_REL;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign wb_pulse  = (state_q == S_WB);
  assign rel_pulse = (state_q == S_REL);
  assign wb_rc     = res_q.rc;
  assign wb_len    = res_q.out_len;

  // R2: the doorbell stays up for the whole processing sequence
  a_r2_db_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |-> db);

  // R7: reported output length is bounded by the payload size
  a_r7_outlen_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pulse |-> (wb_len <= MAX_LEN));

  // R8: no-op with nonzero length is a length error
  a_r8_noop_len: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_pulse && cmd_word[15:0] == 16'h0002 && cmd_word[35:16] != '0)
      |-> (wb_rc == 16'h0016 && wb_len == '0));

  // R9: unsupported opcodes report no output
  a_r9_unsup_len0: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_pulse && wb_rc == 16'h0003) |-> (wb_len == '0));

endmodule

// File: rtl/mbox_regblk.sv
module mbox_regblk
  import mbox_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int PLD_EXP = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata
);

  localparam int PLD_BASE  = 32;
  localparam int PLD_WORDS = (1 << PLD_EXP) / 8;
  localparam int PIDX_W    = PLD_EXP - 3;
  localparam logic [31:0] CAP_WORD = {25'd0, 1'b0, 1'b0, 5'(PLD_EXP)};

  logic [7:0]        acc_be;
  logic [63:0]       wdata_al;
  logic              acc_ok, hit_reg, hit_pld;
  logic [1:0]        reg_word;
  logic [PIDX_W-1:0] pld_idx;

  mbox_bus_lanes #(
    .ADDR_W  (ADDR_W),
    .PLD_BASE(PLD_BASE),
    .PLD_EXP (PLD_EXP)
  ) u_lanes (
    .addr    (req_addr),
    .size    (req_size),
    .wdata   (req_wdata),
    .be      (acc_be),
    .wdata_al(wdata_al),
    .acc_ok  (acc_ok),
    .hit_reg (hit_reg),
    .hit_pld (hit_pld),
    .reg_word(reg_word),
    .pld_idx (pld_idx)
  );

  logic        db_q;
  logic [63:0] cmd_q;
  logic [63:0] status_q;

  // named internal events
  logic wr_fire, rd_fire, db_ring, cmd_host_wr, pld_host_wr;
  logic wb_pulse, rel_pulse;
  logic [15:0]      wb_rc;
  logic [LEN_W-1:0] wb_len;

  assign wr_fire     = req_valid && req_write && acc_ok;
  assign rd_fire     = req_valid && !req_write;
  assign db_ring     = wr_fire && hit_reg && reg_word == 2'd0 && acc_be[4]
                       && wdata_al[32] && !db_q;
  assign cmd_host_wr = wr_fire && hit_reg && reg_word == 2'd1 && !db_q;
  assign pld_host_wr = wr_fire && hit_pld && !db_q;

  mbox_cmd_fsm #(.PLD_EXP(PLD_EXP)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .db       (db_q),
    .cmd_word (cmd_q),
    .wb_pulse (wb_pulse),
    .wb_rc    (wb_rc),
    .wb_len   (wb_len),
    .rel_pulse(rel_pulse)
  );

  logic [63:0] pld_rd_word;

  mbox_payload_ram #(.WORDS(PLD_WORDS)) u_pld (
    .clk    (clk),
    .wr_en  (pld_host_wr),
    .wr_idx (pld_idx),
    .wr_be  (acc_be),
    .wr_data(wdata_al),
    .rd_idx (pld_idx),
    .rd_data(pld_rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q     <= 1'b0;
      cmd_q    <= '0;
      status_q <= '0;
    end else begin
      if (rel_pulse)    db_q <= 1'b0;
      else if (db_ring) db_q <= 1'b1;

      if (wb_pulse)         cmd_q <= {cmd_q[63:36], wb_len, 16'h0000};
      else if (cmd_host_wr) cmd_q <= merge_bytes(cmd_q, wdata_al, acc_be);

      if (wb_pulse) status_q <= {16'h0000, wb_rc, 32'h0000_0000};
    end
  end

  logic [63:0] sel_word;

  always_comb begin
    sel_word = '0;
    if (hit_pld) begin
      sel_word = pld_rd_word;
    end else if (hit_reg) begin
      case (reg_word)
        2'd0:    sel_word = {31'd0, db_q, CAP_WORD};
        2'd1:    sel_word = cmd_q;
        2'd2:    sel_word = status_q;
        default: sel_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= acc_ok ? read_extract(sel_word, req_size, req_addr[2:0]) : '0;
    end
  end

  // R3: the command word is already rewritten when the doorbell falls
  a_r3_rewrite_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(db_q) |-> (cmd_q[15:0] == 16'h0000));

  // R4: the status word only moves on a state-machine writeback
  a_r4_status_fsm_only: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_pulse |=> $stable(status_q));

  // R5: status carries nothing outside the return-code field
  a_r5_status_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[31:0] == 32'h0 && status_q[63:48] == 16'h0));

  // R11: the command word is frozen while a command is in flight
  a_r11_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (db_q && !wb_pulse) |=> $stable(cmd_q));

  // R12: a response follows a read request by exactly one edge
  a_r12_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

endmodule

// File: tb/mbox_regblk_bench.sv
module mbox_regblk_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam logic [ADDR_W-1:0] A_CAP = 12'h000, A_CTRL = 12'h004, A_CMD = 12'h008,
                                A_STS = 12'h010, A_BG = 12'h018, A_PLD = 12'h020;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [1:0]        req_size = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbox_regblk #(.ADDR_W(ADDR_W), .PLD_EXP(11)) u_mbox_regblk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_size (req_size),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  // {set, op, in_len, expected rc, expected out_len}
  localparam int NV = 8;
  localparam logic [71:0] VEC [NV] = '{
    {8'h00, 8'h01, 20'd8,    16'h0000, 20'd8},    // R6 echo
    {8'h00, 8'h01, 20'd0,    16'h0000, 20'd0},    // R6 echo, empty
    {8'h00, 8'h01, 20'd2048, 16'h0000, 20'd2048}, // R7 full payload
    {8'h00, 8'h01, 20'd2049, 16'h0016, 20'd0},    // R7 oversize
    {8'h00, 8'h02, 20'd0,    16'h0000, 20'd0},    // R8 no-op ok
    {8'h00, 8'h02, 20'd4,    16'h0016, 20'd0},    // R8 no-op bad length
    {8'h01, 8'h01, 20'd4,    16'h0003, 20'd0},    // R9 unknown set
    {8'h00, 8'h07, 20'd0,    16'h0003, 20'd0}     // R9 unknown opcode
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [1:0] s, input logic [63:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [1:0] s, output logic [63:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 64'hDEAD_DEAD_DEAD_DEAD;
  endtask

  task automatic ring();
    bus_wr(A_CTRL, 2'd2, 64'h1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(A_CAP, 2'd2, d);  chk("R1 cap", d, 64'h0000_000B);
    bus_rd(A_CTRL, 2'd2, d); chk("R1 ctrl", d, 64'h0);
    bus_rd(A_CMD, 2'd3, d);  chk("R1 cmd", d, 64'h0);
    bus_rd(A_STS, 2'd3, d);  chk("R1 status", d, 64'h0);
    bus_rd(A_BG, 2'd3, d);   chk("R1 bg status", d, 64'h0);

    // R10 payload byte order and sizes
    bus_wr(A_PLD, 2'd3, 64'h1122_3344_5566_7788);
    bus_rd(A_PLD, 2'd0, d);          chk("R10 byte0", d, 64'h88);
    bus_rd(A_PLD + 12'd2, 2'd1, d);  chk("R10 half1", d, 64'h5566);
    bus_rd(A_PLD + 12'd4, 2'd2, d);  chk("R10 word1", d, 64'h1122_3344);
    bus_wr(A_PLD + 12'd1, 2'd0, 64'hAB);
    bus_rd(A_PLD, 2'd3, d);          chk("R10 byte merge", d, 64'h1122_3344_5566_AB88);
    bus_wr(A_PLD + 12'd1, 2'd1, 64'hFFFF);   // misaligned: dropped
    bus_rd(A_PLD, 2'd3, d);          chk("R10 misaligned write", d, 64'h1122_3344_5566_AB88);
    bus_rd(A_PLD + 12'd2, 2'd2, d);  chk("R10 misaligned read", d, 64'h0);

    // table of commands: R3 command rewrite, R5 status code
    for (int i = 0; i < NV; i++) begin
      logic [7:0]  vs, vo;
      logic [19:0] vl, vol;
      logic [15:0] vrc;
      {vs, vo, vl, vrc, vol} = VEC[i];
      bus_wr(A_CMD, 2'd3, {28'h0, vl, vs, vo});
      ring();
      repeat (6) @(negedge clk);
      bus_rd(A_CTRL, 2'd2, d); chk("R2 doorbell cleared", d, 64'h0);
      bus_rd(A_CMD, 2'd3, d);  chk("R3 cmd rewrite", d, {28'h0, vol, 16'h0});
      bus_rd(A_STS, 2'd3, d);  chk("R5 status code", d, {16'h0, vrc, 32'h0});
    end

    // R2 doorbell timing: four reads see 1, fifth sees 0
    bus_wr(A_CMD, 2'd3, {28'h0, 20'd0, 8'h00, 8'h02});
    ring();
    for (int k = 0; k < 5; k++) begin
      bus_rd(A_CTRL, 2'd2, d);
      chk("R2 doorbell sequence", d, (k < 4) ? 64'h1 : 64'h0);
    end

    // R3 upper command bits preserved
    bus_wr(A_CMD, 2'd3, {24'h0, 4'h5, 20'd4, 8'h00, 8'h01});
    ring();
    repeat (6) @(negedge clk);
    bus_rd(A_CMD, 2'd3, d); chk("R3 upper bits kept", d, {24'h0, 4'h5, 20'd4, 16'h0});

    // R11 writes during flight ignored; R6 echo leaves payload intact
    bus_wr(A_PLD, 2'd3, 64'hCAFE_F00D_1234_5678);
    bus_wr(A_CMD, 2'd3, {28'h0, 20'd8, 8'h00, 8'h01});
    ring();
    bus_wr(A_CMD, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_wr(A_PLD, 2'd3, 64'h0);
    repeat (6) @(negedge clk);
    bus_rd(A_CMD, 2'd3, d); chk("R11 cmd frozen", d, {28'h0, 20'd8, 16'h0});
    bus_rd(A_PLD, 2'd3, d); chk("R11 R6 payload intact", d, 64'hCAFE_F00D_1234_5678);
    bus_rd(A_STS, 2'd3, d); chk("R6 echo success", d, 64'h0);

    // R4 read-only words
    bus_wr(A_CMD, 2'd3, {28'h0, 20'd0, 8'h09, 8'h09});
    ring();
    repeat (6) @(negedge clk);
    bus_wr(A_STS, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_wr(A_BG, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_wr(A_CAP, 2'd2, 64'hFFFF_FFFF);
    bus_rd(A_STS, 2'd3, d); chk("R4 status ro", d, {16'h0, 16'h0003, 32'h0});
    bus_rd(A_BG, 2'd3, d);  chk("R4 bg ro", d, 64'h0);
    bus_rd(A_CAP, 2'd2, d); chk("R4 cap ro", d, 64'h0000_000B);

    // R12 response one cycle after request
    req_valid = 1'b1; req_write = 1'b0; req_addr = A_CAP; req_size = 2'd2;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R12 rsp_valid", {63'h0, rsp_valid}, 64'h1);
    @(posedge clk); @(negedge clk);
    chk("R12 rsp_valid drops", {63'h0, rsp_valid}, 64'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule